// File: doc/BRIEF.md
# Prioritized Exception Dispatch Unit

This block holds a set of pending exception flags and, on each dispatch request, picks the single exception that should be taken next. For the chosen exception it works out the saved return address, the saved status word and the updated machine state word. It also produces a redirect target equal to the exception's vector. It then drops the serviced flag from the pending set. Cause generation and handler code live elsewhere. Other logic raises flags through the set inputs, and the core pulses the dispatch input when it reaches a point where exceptions may be taken.

Synchronous causes always win, in a fixed order. The asynchronous group (external interrupt, performance monitor, decrementer) is considered only when no synchronous cause is pending and the interrupt-enable bit of the supplied state word is 1. A debug memory-check hit is a special synchronous case. It silently cancels itself together with any pending data-storage fault, and it produces no redirect.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, `redir_valid_o` is 0 and `redir_pc_o`, `srr0_o`, `srr1_o`, `msr_o` and `pend_o` are all zero.
- R2: A dispatch with an eligible vectoring exception raises `redir_valid_o` for exactly one cycle, in the cycle after `dispatch_i`. In all other cycles `redir_valid_o` is 0. The flag bits of `set_i` and `pend_o` are: 0 instruction-storage fault (vector 0x400), 1 program (0x700), 2 system call (0xC00), 3 FPU unavailable (0x800), 4 debug memory-check hit (no vector), 5 data-storage fault (0x300), 6 alignment (0x600), 7 external interrupt (0x500), 8 performance monitor (0xF00), 9 decrementer (0x900).
- R3: Among pending synchronous flags (bits 0 to 6), the lowest bit index is serviced, and `redir_pc_o` is its vector.
- R4: Asynchronous flags (bits 7 to 9) are eligible only when no synchronous flag is pending and `msr_i[15]` is 1. Otherwise they stay pending and produce no redirect.
- R5: Among eligible asynchronous flags, external interrupt beats performance monitor, which beats decrementer.
- R6: `srr0_o` gets `npc_i` for instruction-storage fault, system call and all asynchronous causes. It gets `pc_i` for program, FPU unavailable, data-storage fault and alignment.
- R7: `srr1_o` gets `msr_i & 0x87C0FFFF`. For the instruction-storage fault, bit 30 is also set.
- R8: For the program exception, `srr1_o` is `srr1_i | (msr_i & 0x87C0FFFF)`, keeping the bits already present.
- R9: `msr_o` is `msr_i` with bit 0 replaced by `msr_i[16]`, then ANDed with the complement of 0x0004EF36.
- R10: A dispatch clears only the serviced flag. A flag set through `set_i` in the same cycle it is serviced stays pending.
- R11: Servicing the debug memory-check hit clears flags 4 and 5 together, with no redirect and no change to `srr0_o`, `srr1_o` or `msr_o`.
- R12: `redir_pc_o`, `srr0_o`, `srr1_o` and `msr_o` hold their values in every cycle that is not a vectoring dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 10 | Pending-flag set pulses, one bit per cause |
| dispatch_i | input | 1 | Take the highest-priority eligible exception now |
| pc_i | input | PCW | Current program counter |
| npc_i | input | PCW | Next program counter |
| msr_i | input | 32 | Current machine state word |
| srr1_i | input | 32 | Present saved-status contents (merged by program exception) |
| redir_valid_o | output | 1 | One-cycle redirect pulse |
| redir_pc_o | output | PCW | Redirect target (vector) |
| srr0_o | output | PCW | New saved return address |
| srr1_o | output | 32 | New saved status |
| msr_o | output | 32 | New machine state word |
| pend_o | output | 10 | Pending flags |

## Verification
The assertions assume that `msr_i`, `pc_i`, `npc_i` and `srr1_i` are stable across the edge on which `dispatch_i` is sampled. They also assume these inputs describe the state the core holds at that moment. The stimulus changes inputs only at the falling edge, so every sampled value is settled. The stimulus mixes directed sequences with a long random phase. In that phase, flags arrive sparsely and the interrupt-enable bit toggles, so that masked asynchronous causes pile up and are then released.

// File: rtl/exc_dispatch.sv
module exc_dispatch #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [9:0]     set_i,
  input  logic           dispatch_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [PCW-1:0] npc_i,
  input  logic [31:0]    msr_i,
  input  logic [31:0]    srr1_i,
  output logic           redir_valid_o,
  output logic [PCW-1:0] redir_pc_o,
  output logic [PCW-1:0] srr0_o,
  output logic [31:0]    srr1_o,
  output logic [31:0]    msr_o,
  output logic [9:0]     pend_o
);
  localparam int NSYNC = 7;
  localparam int NEXC  = 10;
  localparam logic [3:0] NONE = 4'd15;
  localparam logic [3:0] DBG  = 4'd4;
  localparam logic [31:0] SAVE_MASK = 32'h87C0FFFF;
  localparam logic [31:0] CLR_MASK  = 32'h0004EF36;

  logic [NEXC-1:0] pend_q, clr;
  logic [3:0]  sel;
  logic [11:0] vec;
  logic        use_npc, take, vectoring;
  logic [31:0] saved, srr1_new, msr_new;

  always_comb begin
    sel = NONE;
    for (int i = NSYNC - 1; i >= 0; i--)
      if (pend_q[i]) sel = 4'(i);
    if (sel == NONE && msr_i[15])
      for (int i = NEXC - 1; i >= NSYNC; i--)
        if (pend_q[i]) sel = 4'(i);
  end

  always_comb begin
    vec = 12'h000;
    use_npc = 1'b0;
    case (sel)
      4'd0: begin vec = 12'h400; use_npc = 1'b1; end
      4'd1: vec = 12'h700;
      4'd2: begin vec = 12'hC00; use_npc = 1'b1; end
      4'd3: vec = 12'h800;
      4'd5: vec = 12'h300;
      4'd6: vec = 12'h600;
      4'd7: begin vec = 12'h500; use_npc = 1'b1; end
      4'd8: begin vec = 12'hF00; use_npc = 1'b1; end
      4'd9: begin vec = 12'h900; use_npc = 1'b1; end
      default: ;
    endcase
  end

  assign take      = dispatch_i && (sel != NONE);
  assign vectoring = take && (sel != DBG);
  assign saved     = msr_i & SAVE_MASK;
  assign srr1_new  = (sel == 4'd0) ? (saved | 32'h40000000) :
                     (sel == 4'd1) ? (saved | srr1_i) : saved;
  assign msr_new   = {msr_i[31:1], msr_i[16]} & ~CLR_MASK;

  always_comb begin
    clr = '0;
    if (take) begin
      clr[sel] = 1'b1;
      if (sel == DBG) clr[5] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q        <= '0;
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      srr0_o        <= '0;
      srr1_o        <= '0;
      msr_o         <= '0;
    end else begin
      pend_q        <= (pend_q & ~clr) | set_i;
      redir_valid_o <= vectoring;
      if (vectoring) begin
        redir_pc_o <= PCW'(vec);
        srr0_o     <= use_npc ? npc_i : pc_i;
        srr1_o     <= srr1_new;
        msr_o      <= msr_new;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

module exc_dispatch_chk #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [9:0]     set_i,
  input logic           dispatch_i,
  input logic [31:0]    msr_i,
  input logic           redir_valid_o,
  input logic [PCW-1:0] redir_pc_o,
  input logic [31:0]    srr1_o,
  input logic [31:0]    msr_o,
  input logic [9:0]     pend_o
);
  p_pulse_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |-> $past(dispatch_i));

  p_async_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !$past(msr_i[15])) |->
      (redir_pc_o == PCW'(12'h400) || redir_pc_o == PCW'(12'h700) ||
       redir_pc_o == PCW'(12'hC00) || redir_pc_o == PCW'(12'h800) ||
       redir_pc_o == PCW'(12'h300) || redir_pc_o == PCW'(12'h600)));

  p_status_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && redir_pc_o != PCW'(12'h700)) |-> ((srr1_o & ~32'hC7C0FFFF) == 32'h0));

  p_state_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |-> (((msr_o & 32'h0004EF36) == 32'h0) && (msr_o[0] == $past(msr_i[16]))));

  p_served_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && redir_pc_o == PCW'(12'h400) && !$past(set_i[0])) |-> !pend_o[0]);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid_o |-> ($stable(redir_pc_o) && $stable(msr_o) && $stable(srr1_o)));
endmodule

bind exc_dispatch exc_dispatch_chk #(.PCW(PCW)) u_chk (.*);

// File: tb/sim_exc_dispatch.sv
module sim_exc_dispatch;
  logic        clk = 0, rst_n = 0;
  logic [9:0]  set_i = '0;
  logic        dispatch_i = 0;
  logic [31:0] pc_i = 0, npc_i = 0, msr_i = 0, srr1_i = 0;
  logic        redir_valid_o;
  logic [31:0] redir_pc_o, srr0_o, srr1_o, msr_o;
  logic [9:0]  pend_o;

  int checks = 0, fails = 0;
  bit [9:0] mp;
  bit e_rv;
  bit [31:0] e_pc, e_s0, e_s1, e_msr;
  string tag;

  always #2 clk = ~clk;

  exc_dispatch u0 (.*);

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int vec_of(int k);
    case (k)
      0: return 'h400; 1: return 'h700; 2: return 'hC00; 3: return 'h800;
      5: return 'h300; 6: return 'h600; 7: return 'h500; 8: return 'hF00;
      default: return 'h900;
    endcase
  endfunction

  task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic model();
    int s = -1;
    for (int k = 0; k < 7; k++) if (mp[k] && s < 0) s = k;
    if (s < 0 && msr_i[15]) for (int k = 7; k < 10; k++) if (mp[k] && s < 0) s = k;
    e_rv = 0;
    tag = "R12";
    if (!msr_i[15] && s < 0 && (mp[9:7] != 0)) tag = "R4";
    if (dispatch_i && s >= 0) begin
      if (s == 4) begin
        mp[4] = 0; mp[5] = 0; tag = "R11";
      end else begin
        e_rv = 1;
        e_pc = vec_of(s);
        e_s0 = (s == 0 || s == 2 || s >= 7) ? npc_i : pc_i;
        e_s1 = msr_i & 32'h87C0FFFF;
        if (s == 0) e_s1 = e_s1 | (32'd1 << 30);
        if (s == 1) e_s1 = e_s1 | srr1_i;
        e_msr = msr_i;
        e_msr[0] = msr_i[16];
        e_msr = e_msr & ~32'h0004EF36;
        mp[s] = 0;
        tag = (s < 7) ? "R3" : "R5";
      end
    end
    mp = mp | set_i;
  endtask

  task automatic compare();
    chk(redir_valid_o == e_rv, {"R2 valid ", tag}, 32'(redir_valid_o), 32'(e_rv));
    chk(redir_pc_o == e_pc, {"R2 vector ", tag}, redir_pc_o, e_pc);
    chk(srr0_o == e_s0, {"R6 srr0 ", tag}, srr0_o, e_s0);
    chk(srr1_o == e_s1, {"R7 R8 srr1 ", tag}, srr1_o, e_s1);
    chk(msr_o == e_msr, {"R9 msr ", tag}, msr_o, e_msr);
    chk(pend_o == mp, {"R10 pending ", tag}, 32'(pend_o), 32'(mp));
  endtask

  task automatic go(bit [9:0] s, bit d, bit [31:0] m, bit [31:0] r1);
    set_i = s; dispatch_i = d; msr_i = m; srr1_i = r1;
    pc_i = $urandom; npc_i = pc_i + 4;
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    mp = 0; e_rv = 0; e_pc = 0; e_s0 = 0; e_s1 = 0; e_msr = 0;
    repeat (3) @(negedge clk);
    chk(redir_valid_o == 0 && redir_pc_o == 0 && srr0_o == 0 && srr1_o == 0 &&
        msr_o == 0 && pend_o == 0, "R1 reset", 32'(pend_o), 0);
    rst_n = 1;
    @(negedge clk);
    // R3: instruction fault beats data fault
    go(10'b0000100001, 0, 32'h0001_A0F3, 0);
    go(0, 1, 32'h0001_A0F3, 0);
    go(0, 1, 32'h0000_8032, 0);
    // R8: program merges existing saved status
    go(10'b0000000010, 0, 32'h8000_0030, 0);
    go(0, 1, 32'hFFFF_FFFF, 32'h0002_0000);
    // R6: system call vs FPU unavailable
    go(10'b0000001100, 0, 32'h0, 0);
    go(0, 1, 32'h0, 0);
    go(0, 1, 32'h0, 0);
    // R11: debug hit cancels data fault
    go(10'b0000110000, 0, 32'h8000, 0);
    go(0, 1, 32'h8000, 0);
    go(0, 1, 32'h8000, 0);
    // R4: async masked then R5 order
    go(10'b1110000000, 0, 32'h0, 0);
    go(0, 1, 32'h0, 0);
    go(0, 1, 32'h0, 0);
    go(0, 1, 32'h0001_8000, 0);
    go(0, 1, 32'h8000, 0);
    go(0, 1, 32'h8000, 0);
    go(0, 1, 32'h8000, 0);
    // sync beats async even with enable set
    go(10'b1001000000, 0, 32'h8000, 0);
    go(0, 1, 32'h8000, 0);
    go(0, 1, 32'h8000, 0);
    // R10: re-set same cycle as service
    go(10'b0000000001, 0, 32'h0, 0);
    go(10'b0000000001, 1, 32'h0, 0);
    go(0, 1, 32'h0, 0);
    go(0, 1, 32'h0, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit [9:0] s = 0;
      for (int b = 0; b < 10; b++) if ($urandom_range(0, 15) == 0) s[b] = 1;
      go(s, $urandom_range(0, 2) == 0, $urandom ^ (($urandom_range(0, 1)) << 15), $urandom);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule